// File: doc/BRIEF.md
# RSSI Pulse-Width Carrier Detector

This block turns received signal strength into a carrier-present decision without an ADC. Once per measurement period it raises a discharge strobe that empties an external ramp capacitor. When the strobe ends, the ramp starts to charge. An external comparator stays high while the ramp is still below the RSSI voltage. A stronger signal means a higher RSSI voltage, so the comparator stays high for longer.

The block synchronizes the comparator output and counts the clock cycles of that high interval. At the end of each period it publishes the count with a one-cycle valid strobe. It also compares the count against a threshold word that software loads from non-volatile storage. The carrier flag sets on a single strong period. It clears only after a parameterized run of weak periods, which stops the flag from chattering near the threshold.

The period length, discharge length, count width, synchronizer depth and hysteresis run length are all parameters. The default period is 1 ms at a 200 MHz clock.

Top module: `rssi_cd_meter`

## Requirements
- R1: While enabled, `dis_o` is high for the first DISCH_CYCLES cycles of every PERIOD_CYCLES-cycle period and low for the rest of the period. Periods follow one another with no gap.
- R2: The comparator input passes through SYNC_STAGES flops (default 2) before it is used. The measured width is the number of cycles after the discharge in which the synchronized comparator is high, counted up to its first low cycle. A raw input held high from the discharge until K clock edges after `dis_o` falls therefore gives K+2 with the default synchronizer.
- R3: The width count saturates at 2^WIDTH_W-1 and does not wrap.
- R4: Once the synchronized comparator has been low in a period, it is ignored for the rest of that period, even if it goes high again.
- R5: On the clock edge that ends a period, `width_o` takes the final count and `valid_o` is high for exactly one cycle. The first period after reset or after enable rises gives no valid strobe, and `width_o` stays 0 through that period.
- R6: On each valid strobe, `cd_o` is set if `width_o >= thr_i`, comparing unsigned values. `cd_o` changes only together with a valid strobe.
- R7: `cd_o` clears only after CLR_PERIODS consecutive valid periods (default 2) whose width is below the threshold. A period at or above the threshold restarts that run.
- R8: While `en_i` is low, `dis_o`, `valid_o`, `cd_o` and `width_o` are 0. When `en_i` rises, a new period starts with `dis_o` high in the same cycle.
- R9: While reset is asserted with `en_i` low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Measurement enable; low acts as a soft clear |
| cmp_i | input | 1 | Asynchronous comparator output, high while the ramp is below RSSI |
| thr_i | input | WIDTH_W | Carrier threshold in clock cycles |
| dis_o | output | 1 | Ramp discharge strobe |
| width_o | output | WIDTH_W | Latest published pulse width |
| valid_o | output | 1 | One-cycle strobe when `width_o` and `cd_o` update |
| cd_o | output | 1 | Carrier-detect flag |

## Verification
The bench sweeps the comparator high time across the whole measurement window. A design that miscounted the synchronizer delay, counted the discharge cycles, or missed the final edge of the window would be off by a constant in every period. Near the top of the sweep the count must stop at its ceiling; a design without saturation would wrap to a small value and drop the carrier. A pulse that falls and then rises again checks that late comparator activity is ignored, and a comparator that is low all period checks a width of zero.

Width-equals-threshold cases and runs of one and two weak periods check the hysteresis: a design off by one would either drop the flag after one weak period or keep it after two. Dropping and restoring the enable checks that no stale valid strobe comes out of the first period.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
   // Timing phase inside one measurement period
   typedef struct packed {
      logic dis;   // ramp discharge active
      logic win;   // measurement window active
      logic last;  // final cycle of the period
   } rcd_phase_t;
endpackage

// File: rtl/rcd_period_timer.sv
module rcd_period_timer
   import rcd_pkg::*;
#(
   parameter int PERIOD_CYCLES = 200000,
   parameter int DISCH_CYCLES  = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   output rcd_phase_t ph_o
);
   localparam int CW = $clog2(PERIOD_CYCLES);
   localparam logic [CW-1:0] LAST_V = CW'(PERIOD_CYCLES - 1);
   localparam logic [CW-1:0] DIS_V  = CW'(DISCH_CYCLES);

   logic [CW-1:0] pcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i)       pcnt_q <= '0;
      else if (pcnt_q == LAST_V) pcnt_q <= '0;
      else                       pcnt_q <= pcnt_q + 1'b1;
   end

   always_comb begin
      ph_o.dis  = en_i && (pcnt_q <  DIS_V);
      ph_o.win  = en_i && (pcnt_q >= DIS_V);
      ph_o.last = en_i && (pcnt_q == LAST_V);
   end

   // R1
   next_disch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_o.last && en_i |=> ph_o.dis || !en_i);

   // R1
   disch_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph_o.dis) && $past(en_i) |-> $past(ph_o.last));
endmodule

// File: rtl/rcd_sync.sv
module rcd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh_q;
   logic [STAGES-1:0] sh_nxt;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         assign sh_nxt[i] = d_i;
      end else begin : g_rest
         assign sh_nxt[i] = sh_q[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_nxt;
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rcd_width_ctr.sv
module rcd_width_ctr #(
   parameter int WIDTH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               win_i,
   input  logic               last_i,
   input  logic               cmp_s_i,
   output logic [WIDTH_W-1:0] meas_o
);
   logic [WIDTH_W-1:0] cnt_q;
   logic [WIDTH_W-1:0] cnt_nxt;
   logic               run_q;
   logic               inc;

   always_comb begin
      inc     = win_i && run_q && cmp_s_i;
      cnt_nxt = (inc && !(&cnt_q)) ? cnt_q + 1'b1 : cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i || last_i) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (win_i) begin
         cnt_q <= cnt_nxt;
         if (!cmp_s_i) run_q <= 1'b0;
      end
   end

   // final count including the closing edge of the window
   assign meas_o = cnt_nxt;

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt_q) && win_i && !last_i |=> (&cnt_q) || (cnt_q == '0));

   // R4
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_i && !run_q && !last_i |=> $stable(cnt_q) || (cnt_q == '0));

   // R2
   no_count_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_s_i && !last_i && en_i |=> $stable(cnt_q) || (cnt_q == '0));
endmodule

// File: rtl/rcd_decide.sv
module rcd_decide #(
   parameter int WIDTH_W     = 16,
   parameter int CLR_PERIODS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               last_i,
   input  logic [WIDTH_W-1:0] meas_i,
   input  logic [WIDTH_W-1:0] thr_i,
   output logic [WIDTH_W-1:0] width_o,
   output logic               valid_o,
   output logic               cd_o
);
   logic primed_q;
   logic upd;
   logic hit;
   logic drop;

   assign upd = last_i && primed_q;
   assign hit = (meas_i >= thr_i);

   if (CLR_PERIODS == 1) begin : g_no_hyst
      assign drop = !hit;
   end else begin : g_hyst
      localparam int MW = $clog2(CLR_PERIODS + 1);
      localparam logic [MW-1:0] MISS_TOP = MW'(CLR_PERIODS - 1);
      logic [MW-1:0] miss_q;

      assign drop = !hit && (miss_q == MISS_TOP);

      always_ff @(posedge clk) begin
         if (!rst_n || !en_i)          miss_q <= '0;
         else if (upd && hit)          miss_q <= '0;
         else if (upd && miss_q != MISS_TOP) miss_q <= miss_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         primed_q <= 1'b0;
         valid_o  <= 1'b0;
         width_o  <= '0;
         cd_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (last_i) primed_q <= 1'b1;
         if (upd) begin
            valid_o <= 1'b1;
            width_o <= meas_i;
            if (hit)       cd_o <= 1'b1;
            else if (drop) cd_o <= 1'b0;
         end
      end
   end

   // R5
   one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R5
   valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(last_i));

   // R6
   rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cd_o) |-> valid_o && (width_o >= $past(thr_i)));

   // R7
   fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cd_o) && $past(en_i) |-> $past(meas_i < thr_i) && valid_o);
endmodule

// File: rtl/rssi_cd_meter.sv
module rssi_cd_meter
   import rcd_pkg::*;
#(
   parameter int PERIOD_CYCLES = 200000,
   parameter int DISCH_CYCLES  = 20,
   parameter int WIDTH_W       = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int CLR_PERIODS   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               cmp_i,
   input  logic [WIDTH_W-1:0] thr_i,
   output logic               dis_o,
   output logic [WIDTH_W-1:0] width_o,
   output logic               valid_o,
   output logic               cd_o
);
   if (DISCH_CYCLES < 1 || DISCH_CYCLES > PERIOD_CYCLES - 2) begin : g_bad_disch
      $error("rssi_cd_meter: DISCH_CYCLES must leave a window in the period");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rssi_cd_meter: SYNC_STAGES must be at least 2");
   end
   if (WIDTH_W < 2 || WIDTH_W > 32) begin : g_bad_width
      $error("rssi_cd_meter: WIDTH_W out of range");
   end
   if (CLR_PERIODS < 1) begin : g_bad_clr
      $error("rssi_cd_meter: CLR_PERIODS must be at least 1");
   end

   rcd_phase_t         ph;
   logic               cmp_s;
   logic [WIDTH_W-1:0] meas;

   rcd_period_timer #(
      .PERIOD_CYCLES(PERIOD_CYCLES),
      .DISCH_CYCLES (DISCH_CYCLES)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .en_i (en_i),
      .ph_o (ph)
   );

   rcd_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (cmp_i),
      .q_o  (cmp_s)
   );

   rcd_width_ctr #(
      .WIDTH_W(WIDTH_W)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .win_i  (ph.win),
      .last_i (ph.last),
      .cmp_s_i(cmp_s),
      .meas_o (meas)
   );

   rcd_decide #(
      .WIDTH_W    (WIDTH_W),
      .CLR_PERIODS(CLR_PERIODS)
   ) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .last_i (ph.last),
      .meas_i (meas),
      .thr_i  (thr_i),
      .width_o(width_o),
      .valid_o(valid_o),
      .cd_o   (cd_o)
   );

   assign dis_o = ph.dis;

   // R8
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !valid_o && !cd_o && (width_o == '0));

   // R8
   idle_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !dis_o);
endmodule

// File: tb/tb_rssi_cd_meter.sv
`timescale 1ns/1ps
module tb_rssi_cd_meter;
   localparam int PER  = 40;
   localparam int DIS  = 3;
   localparam int W    = 5;
   localparam int CLR  = 2;
   localparam int WMAX = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         cmp = 1'b0;
   logic [W-1:0] thr = '0;
   logic         dis_o;
   logic [W-1:0] width_o;
   logic         valid_o;
   logic         cd_o;

   int total = 0;
   int bad = 0;
   int m_cd = 0;
   int m_miss = 0;

   always #2.5 clk = ~clk;

   rssi_cd_meter #(
      .PERIOD_CYCLES(PER),
      .DISCH_CYCLES (DIS),
      .WIDTH_W      (W),
      .SYNC_STAGES  (2),
      .CLR_PERIODS  (CLR)
   ) dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .cmp_i  (cmp),
      .thr_i  (thr),
      .dis_o  (dis_o),
      .width_o(width_o),
      .valid_o(valid_o),
      .cd_o   (cd_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // At a negedge where enable has just risen: the first period, no valid (R5, R1, R8)
   task automatic first_period();
      int hi = 0;
      int sawv = 0;
      int sawc = 0;
      #1;
      check(dis_o == 1'b1, "R8 dis on enable", int'(dis_o), 1);
      for (int i = 0; i < PER; i++) begin
         if (dis_o) hi++;
         if (valid_o) sawv++;
         if (width_o != '0) sawc++;
         @(negedge clk);
      end
      check(hi == DIS, "R1 discharge length", hi, DIS);
      check(sawv == 0 && !valid_o, "R5 no valid in first period", sawv, 0);
      check(sawc == 0, "R5 width held at 0 in first period", sawc, 0);
      check(dis_o == 1'b1, "R1 period length", int'(dis_o), 1);
      m_cd = 0;
      m_miss = 0;
   endtask

   // mode 0: high k edges past discharge; 1: low all period; 2: high, low 2, high again
   task automatic run_period(input int k, input int mode, input string req);
      int expw;
      int lim = 0;
      cmp = (mode != 1);
      while (dis_o) @(negedge clk);
      if (mode != 1) begin
         repeat (k) @(negedge clk);
         cmp = 1'b0;
         if (mode == 2) begin
            repeat (2) @(negedge clk);
            cmp = 1'b1;
         end
      end
      while (!valid_o && lim < 2 * PER) begin
         @(negedge clk);
         lim++;
      end
      expw = (mode == 1) ? 0 : ((k + 2 > WMAX) ? WMAX : k + 2);
      if (expw >= int'(thr)) begin
         m_cd = 1;
         m_miss = 0;
      end else begin
         m_miss++;
         if (m_miss >= CLR) m_cd = 0;
      end
      check(valid_o == 1'b1, "R5 valid at period end", int'(valid_o), 1);
      check(int'(width_o) == expw, req, int'(width_o), expw);
      check(int'(cd_o) == m_cd, "R6 R7 carrier flag", int'(cd_o), m_cd);
      @(negedge clk);
      check(valid_o == 1'b0, "R5 valid one cycle", int'(valid_o), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      check(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(!dis_o && !valid_o && !cd_o && width_o == '0, "R9 reset outputs", int'(dis_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!dis_o && !valid_o && !cd_o, "R8 idle outputs", int'(dis_o), 0);
      cmp = 1'b1;
      en  = 1'b1;
      first_period();

      // R2 R3 sweep of comparator high time across the window, threshold 16
      thr = W'(16);
      for (int k = 0; k <= 34; k++) run_period(k, 0, "R2 R3 width sweep");

      // R7 hysteresis with threshold 10: width == thr counts as a hit
      thr = W'(10);
      run_period(18, 0, "R7 strong");
      run_period(3, 0, "R7 one weak keeps flag");
      run_period(8, 0, "R6 width equals threshold");
      run_period(7, 0, "R7 first below");
      run_period(7, 0, "R7 second below drops");
      run_period(8, 0, "R6 boundary sets again");

      // R4 comparator rises again after falling
      run_period(5, 2, "R4 late comparator ignored");
      run_period(20, 2, "R4 late comparator ignored long");
      // R2 comparator low all period
      run_period(0, 1, "R2 zero width");
      run_period(0, 1, "R2 zero width again");

      // R6 extreme thresholds
      thr = W'(0);
      run_period(0, 1, "R6 zero threshold");
      thr = W'(WMAX);
      run_period(33, 0, "R3 R6 saturated meets max threshold");

      // R8 enable drop and restart
      en = 1'b0;
      @(negedge clk);
      check(!dis_o && !valid_o && !cd_o && width_o == '0, "R8 cleared by enable", int'(cd_o), 0);
      repeat (5) @(negedge clk);
      check(!dis_o, "R8 no discharge while idle", int'(dis_o), 0);
      cmp = 1'b1;
      en  = 1'b1;
      first_period();
      thr = W'(12);
      run_period(12, 0, "R2 after restart");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule